// File: doc/BRIEF.md
# First-Event Interrupt Status Capture

This block holds the 32-bit interrupt status word of a bus-bridge controller. Single-cycle event pulses from the bridge's protocol engines arrive on a set of source lines. The word captures only the first event that arrives while it is empty, so software sees the root cause of a fault rather than the cascade of errors that follows it. A per-source enable mask decides whether a captured source drives the interrupt line. A masked source is still recorded.

The local bus master reads the word and clears bits by writing ones to them. The second bus reads the same word through a port that has no write path. The block also contains a small detector for I/O target accesses. It flags an abort when the byte enables do not agree with the low address bits, and that abort is one of the captured sources.

Top module: `bic_status_top`

## Requirements
- R1: While any status bit is set, a new event sets no further bit. Only the first event after the word becomes empty is recorded.
- R2: When events on several sources arrive in the same cycle and the word is empty, only the lowest-numbered bit among them is set. The abort flag at bit 14 loses to any source on bits 9 to 0.
- R3: A local write clears each status bit whose write-data bit is 1, and writing 0 has no effect. If a clear and an event fall in the same cycle, the clear acts first, and the event is then judged against the cleared word.
- R4: Reset sets the word to 0. Bits 31 to 15 and 13 to 10 always read 0 and ignore writes.
- R5: `irq_o` is the OR over all bits of status AND enable. A masked source is still recorded but keeps `irq_o` low. `irq_o` follows the status word with no further delay, so it falls in the cycle after the clearing write.
- R6: Bit 14 is set when an I/O target transfer has either of two faults: no byte enabled, or a lowest enabled lane (byte enables are active low, lane k = bit k) below the lane selected by address bits 1:0. A transfer whose lowest enabled lane is at or above that lane is legal. No abort is flagged when no transfer is marked.
- R7: The second-bus read port always shows the same value as the local read port.
- R8: Event line k (k = 0 to 9) maps to status bit k. The captured status appears on both read ports one clock after the event pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | 10 | Single-cycle event pulses for status bits 9..0 |
| io_tgt_xfer_i | input | 1 | Marks a cycle carrying an I/O target transfer |
| io_addr_lo_i | input | 2 | Address bits 1:0 of that transfer |
| io_be_n_i | input | 4 | Active-low byte enables of that transfer |
| irq_en_i | input | 32 | Per-bit interrupt enable mask |
| wr_en_i | input | 1 | Local write strobe to the status word |
| wr_data_i | input | 32 | Local write data (ones clear) |
| loc_rdata_o | output | 32 | Status word, local read |
| pci_rdata_o | output | 32 | Status word, second-bus read |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: a 32-bit word, ten low sources, the abort flag at bit 14 and four byte lanes. This brings every source, every reserved gap and the full set of address and byte-enable combinations within reach. The directed scenarios cover the following cases:
- a first capture, then later events that must be ignored;
- same-cycle contention between sources, including the abort flag against a low source;
- a clear and an event landing in the same cycle;
- masked capture;
- legal and illegal byte-enable patterns at several lane offsets.

// File: rtl/bic_pkg.sv
// Shared layout constants for the interrupt status capture block.
package bic_pkg;
    localparam int REG_W    = 32; // width of the status word
    localparam int NUM_LOW  = 10; // sources packed at bits NUM_LOW-1..0
    localparam int TA_POS   = 14; // bit position of the target-abort flag
    localparam int BE_LANES = 4;  // byte lanes of an I/O target transfer
endpackage

// File: rtl/bic_ta_detect.sv
// Target-abort detector for I/O target transfers.
// Flags an abort when no lane is enabled, or when the lowest enabled
// lane (active-low enables) lies below the lane chosen by the low address.
// Assumes the inputs are valid only while xfer_i is high. The output is combinational.
module bic_ta_detect #(
    parameter int BE_W = bic_pkg::BE_LANES,
    localparam int AW  = $clog2(BE_W)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            xfer_i,
    input  logic [AW-1:0]   addr_lo_i,
    input  logic [BE_W-1:0] be_n_i,
    output logic            ta_evt_o
);
    logic [AW-1:0] low_lane;
    logic          any_en;

    // Find the lowest enabled lane and judge it against the address.
    always_comb begin
        low_lane = '0;
        any_en   = 1'b0;
        for (int i = BE_W - 1; i >= 0; i--) begin
            if (!be_n_i[i]) begin
                low_lane = AW'(i);
                any_en   = 1'b1;
            end
        end
        ta_evt_o = xfer_i && (!any_en || (low_lane < addr_lo_i));
    end

    AST_TA_NO_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_i && (&be_n_i)) |-> ta_evt_o); // R6
    AST_TA_IDLE:    assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_i |-> !ta_evt_o); // R6
endmodule

// File: rtl/bic_first_latch.sv
// First-event capture register with write-one-to-clear.
// The clear mask acts first. If nothing is left pending afterwards, the
// lowest-numbered valid event is latched. Otherwise events are dropped.
// Assumes event bits are single-cycle pulses.
module bic_first_latch #(
    parameter int              W     = bic_pkg::REG_W,
    parameter logic [W-1:0]    VALID = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] ev_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] status_q
);
    logic [W-1:0] kept;
    logic [W-1:0] ev_m;
    logic [W-1:0] win;
    logic [W-1:0] status_d;

    // Apply the clear, isolate the lowest event, and capture only when empty.
    always_comb begin
        kept     = status_q & ~clr_i;
        ev_m     = ev_i & VALID;
        win      = ev_m & (~ev_m + W'(1));
        status_d = (kept == '0) ? win : kept;
    end

    // Status register with a synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= status_d;
    end

    AST_NO_LATE_SET:  assert property (@(posedge clk) disable iff (!rst_n)
        ((status_q & ~clr_i) != '0) |=> ((status_q & ~$past(status_q)) == '0)); // R1
    AST_SINGLE_WIN:   assert property (@(posedge clk) disable iff (!rst_n)
        ((status_q & ~clr_i) == '0) |=> $onehot0(status_q)); // R2
    AST_CLEAR_ACTS:   assert property (@(posedge clk) disable iff (!rst_n)
        (((status_q & clr_i) != '0) && ((status_q & ~clr_i) != '0))
        |=> ((status_q & $past(status_q & clr_i)) == '0)); // R3
endmodule

// File: rtl/bic_status_top.sv
// Interrupt status word of a bus bridge.
// Gathers event pulses and the I/O target-abort detector into one word
// with first-event capture. The word offers write-one-to-clear from the
// local side and a read-only mirror for the second bus. irq_o is the
// enabled OR of the word. Assumes wr_en_i is a single-cycle strobe per write.
module bic_status_top #(
    parameter int REG_W   = bic_pkg::REG_W,
    parameter int NUM_LOW = bic_pkg::NUM_LOW,
    parameter int TA_POS  = bic_pkg::TA_POS,
    parameter int BE_W    = bic_pkg::BE_LANES,
    localparam int AW     = $clog2(BE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_LOW-1:0] evt_i,
    input  logic              io_tgt_xfer_i,
    input  logic [AW-1:0]     io_addr_lo_i,
    input  logic [BE_W-1:0]   io_be_n_i,
    input  logic [REG_W-1:0]  irq_en_i,
    input  logic              wr_en_i,
    input  logic [REG_W-1:0]  wr_data_i,
    output logic [REG_W-1:0]  loc_rdata_o,
    output logic [REG_W-1:0]  pci_rdata_o,
    output logic              irq_o
);
    localparam logic [REG_W-1:0] LOW_MASK = (REG_W'(1) << NUM_LOW) - REG_W'(1);
    localparam logic [REG_W-1:0] VALID    = LOW_MASK | (REG_W'(1) << TA_POS);

    logic             ta_evt;
    logic [REG_W-1:0] ev_vec;
    logic [REG_W-1:0] clr_vec;
    logic [REG_W-1:0] status;

    bic_ta_detect #(.BE_W(BE_W)) ta_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .xfer_i    (io_tgt_xfer_i),
        .addr_lo_i (io_addr_lo_i),
        .be_n_i    (io_be_n_i),
        .ta_evt_o  (ta_evt)
    );

    // Place the sources at their bit positions in the word.
    always_comb begin
        ev_vec                = '0;
        ev_vec[NUM_LOW-1:0]   = evt_i;
        ev_vec[TA_POS]        = ta_evt;
    end

    // Turn a local write into a clear mask over the writable bits only.
    always_comb begin
        clr_vec = wr_en_i ? (wr_data_i & VALID) : '0;
    end

    bic_first_latch #(.W(REG_W), .VALID(VALID)) latch_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_i     (ev_vec),
        .clr_i    (clr_vec),
        .status_q (status)
    );

    // Drive both read views and the enabled interrupt request.
    always_comb begin
        loc_rdata_o = status;
        pci_rdata_o = status;
        irq_o       = |(status & irq_en_i);
    end

    AST_RSV_ZERO:  assert property (@(posedge clk) disable iff (!rst_n)
        ((loc_rdata_o & ~VALID) == '0)); // R4
    AST_IRQ_IDLE:  assert property (@(posedge clk) disable iff (!rst_n)
        (loc_rdata_o == '0) |-> !irq_o); // R5
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en_i == '0) |-> !irq_o); // R5
endmodule

// File: tb/bic_status_top_tb_top.sv
// Directed bench for bic_status_top: one task per scenario.
module bic_status_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  evt = '0;
    logic        xfer = 1'b0;
    logic [1:0]  addr = '0;
    logic [3:0]  be_n = 4'hF;
    logic [31:0] en = '1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] loc_rd, pci_rd;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk; // 125 MHz

    bic_status_top dut_i (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .io_tgt_xfer_i(xfer),
        .io_addr_lo_i(addr), .io_be_n_i(be_n), .irq_en_i(en),
        .wr_en_i(wr_en), .wr_data_i(wr_data),
        .loc_rdata_o(loc_rd), .pci_rdata_o(pci_rd), .irq_o(irq)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Check the status word on both ports and the interrupt line.
    task automatic chk_state(input string req, input logic [31:0] exp_st, input logic exp_irq);
        chk(req, loc_rd, exp_st);
        chk({req, " R7 mirror"}, pci_rd, exp_st);
        chk({req, " R5 irq"}, {31'b0, irq}, {31'b0, exp_irq});
    endtask

    // One cycle of stimulus, held from negedge to negedge. Results are then visible.
    task automatic cycle(input logic [9:0] e, input logic w, input logic [31:0] d);
        @(negedge clk);
        evt = e; wr_en = w; wr_data = d;
        @(negedge clk);
        evt = '0; wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic io_cycle(input logic x, input logic [1:0] a, input logic [3:0] b, input logic [9:0] e);
        @(negedge clk);
        xfer = x; addr = a; be_n = b; evt = e;
        @(negedge clk);
        xfer = 1'b0; addr = '0; be_n = 4'hF; evt = '0;
    endtask

    task automatic t_reset;
        chk_state("R4 reset", 32'h0, 1'b0);
    endtask

    task automatic t_first;
        cycle(10'h008, 1'b0, '0);
        chk_state("R8 bit3 capture", 32'h8, 1'b1);
        cycle(10'h020, 1'b0, '0);
        chk_state("R1 later event ignored", 32'h8, 1'b1);
        io_cycle(1'b1, 2'd2, 4'b1110, '0);
        chk_state("R1 later abort ignored", 32'h8, 1'b1);
    endtask

    task automatic t_w1c;
        cycle('0, 1'b1, 32'h0);
        chk_state("R3 write zero no effect", 32'h8, 1'b1);
        cycle('0, 1'b1, 32'h20);
        chk_state("R3 clear of unset bit", 32'h8, 1'b1);
        cycle('0, 1'b1, 32'h8);
        chk_state("R3 W1C clears, R5 irq falls", 32'h0, 1'b0);
    endtask

    task automatic t_simul;
        cycle(10'h284, 1'b0, '0);
        chk_state("R2 lowest wins", 32'h4, 1'b1);
        cycle('0, 1'b1, 32'hFFFF_FFFF);
        chk_state("R3 clear all", 32'h0, 1'b0);
        cycle('0, 1'b1, 32'hFFFF_FFFF);
        chk_state("R4 reserved ignore writes", 32'h0, 1'b0);
        cycle(10'h200, 1'b0, '0);
        chk_state("R8 bit9 capture", 32'h200, 1'b1);
        cycle('0, 1'b1, 32'h200);
    endtask

    task automatic t_mask;
        en = ~32'h40;
        cycle(10'h040, 1'b0, '0);
        chk_state("R5 masked recorded, no irq", 32'h40, 1'b0);
        @(negedge clk);
        en = '1;
        #1;
        chk("R5 enable raises irq", {31'b0, irq}, 32'h1);
        cycle('0, 1'b1, 32'h40);
        chk_state("R5 cleared", 32'h0, 1'b0);
    endtask

    task automatic t_clr_evt;
        cycle(10'h002, 1'b0, '0);
        chk_state("R8 bit1 capture", 32'h2, 1'b1);
        cycle(10'h010, 1'b1, 32'h2);
        chk_state("R3 clear then new event", 32'h10, 1'b1);
        cycle(10'h010, 1'b1, 32'h10);
        chk_state("R3 same-bit clear and event", 32'h10, 1'b1);
        cycle(10'h001, 1'b1, 32'h0);
        chk_state("R1 event ignored, zero write", 32'h10, 1'b1);
        cycle('0, 1'b1, 32'h10);
    endtask

    task automatic t_abort;
        io_cycle(1'b1, 2'd2, 4'b0011, '0);
        chk_state("R6 legal lanes 3:2 at addr2", 32'h0, 1'b0);
        io_cycle(1'b1, 2'd3, 4'b0111, '0);
        chk_state("R6 legal lane3 at addr3", 32'h0, 1'b0);
        io_cycle(1'b0, 2'd3, 4'b1111, '0);
        chk_state("R6 no transfer no abort", 32'h0, 1'b0);
        io_cycle(1'b1, 2'd2, 4'b1110, '0);
        chk_state("R6 lane0 below addr2", 32'h4000, 1'b1);
        cycle('0, 1'b1, 32'h4000);
        chk_state("R3 abort cleared", 32'h0, 1'b0);
        io_cycle(1'b1, 2'd0, 4'b1111, '0);
        chk_state("R6 no lane enabled", 32'h4000, 1'b1);
        cycle('0, 1'b1, 32'h4000);
        io_cycle(1'b1, 2'd1, 4'b1001, '0);
        chk_state("R6 lanes 2:1 at addr1 legal", 32'h0, 1'b0);
        io_cycle(1'b1, 2'd3, 4'b1011, 10'h001);
        chk_state("R2 bit0 beats abort", 32'h1, 1'b1);
        cycle('0, 1'b1, 32'h1);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_first();
        t_w1c();
        t_simul();
        t_mask();
        t_clr_evt();
        t_abort();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule